// File: doc/BRIEF.md
# Paged program counter unit

This block holds the program counter of a small microcontroller core. The counter is 13 bits wide and split into an 8-bit low byte and a 5-bit page. The core can read and write the low byte like any data register. The page bits cannot be read back. Software sets them only through a separate write-only page latch, and the latch is copied into the counter when a load happens.

Each cycle the counter either holds, steps by one, or takes a new value. A new value comes from one of four sources: a data-path write to the low byte, an absolute jump or call carrying an 11-bit target, a return value popped from the call stack, or the fixed interrupt vector. A low-byte write takes all five page bits from the latch. A jump takes only the top two latch bits and fills the rest from its target. A computed jump is done by adding an offset to the low byte and writing the result back. That write never carries into the page, so a table that runs past a 256-word boundary wraps back to the start of the same page. Instruction decode, program memory and the stack itself live outside this block.

Top module: `pgc_top`

## Requirements
- R1: Reset is asynchronous and active low. It clears the counter to 0 and the page latch to 0. A low-byte write of D as the first action after reset yields PC = D.
- R2: `lo_rdata` always equals PC bits 7:0.
- R3: With no load request, `inc_en` high advances the PC by 1 modulo 8192 on the next edge, carrying from bit 7 into bit 8. With `inc_en` low the PC holds.
- R4: A low-byte write with data D sets PC = {latch[4:0], D}. The old page of the PC plays no part, so an offset added to the low byte wraps within the page.
- R5: A jump/call with target T sets PC = {latch[4:3], T[10:0]}.
- R6: A latch write changes the latch at the next edge and does not change the PC by itself. A load in the same cycle as a latch write uses the latch value from before that write.
- R7: A return load with value V sets PC = V on all 13 bits.
- R8: An interrupt vector load sets PC = 0x0004.
- R9: When several requests are active at once, the one that takes effect follows this order, highest first: interrupt vector, return load, jump/call, low-byte write, increment.
- R10: Only a latch write changes the page latch. Return, interrupt, jump and low-byte loads leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inc_en | input | 1 | Advance the PC by one |
| lo_wr | input | 1 | Low-byte write strobe |
| lo_wdata | input | 8 | Low-byte write data |
| jmp_en | input | 1 | Jump/call strobe |
| jmp_tgt | input | 11 | Jump/call target from the opcode |
| lat_wr | input | 1 | Page latch write strobe |
| lat_wdata | input | 5 | Page latch write data |
| ret_ld | input | 1 | Return load strobe |
| ret_val | input | 13 | Return address from the stack |
| irq_ld | input | 1 | Interrupt vector load strobe |
| pc_q | output | 13 | Current program counter |
| lo_rdata | output | 8 | Readable low byte of the PC |

## Verification
The bench sweeps all 32 latch values. Under each one it issues low-byte writes with edge data such as 00, 7F, 80 and FF, and jumps with targets at 000, 3FF, 400 and 7FF. These sweeps separate a page built from all five latch bits from one built from only the top two. Increment runs cross the 0FF to 100 boundary and the 1FFF to 0 wrap, while a computed low-byte write crossing 0xFF stays in its page. Together they show that the increment carries into the page and the low-byte write does not. All 64 combinations of the five load strobes plus the latch write are applied, followed by low-byte writes that expose the latch. This confirms the priority order and that the latch survives every kind of load.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
   typedef enum logic [2:0] {
      PGC_HOLD = 3'd0,
      PGC_INC  = 3'd1,
      PGC_LOW  = 3'd2,
      PGC_JUMP = 3'd3,
      PGC_RET  = 3'd4,
      PGC_VEC  = 3'd5
   } pgc_sel_e;
endpackage

// File: rtl/pgc_latch.sv
module pgc_latch #(
   parameter int unsigned LAT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [LAT_W-1:0] wr_data,
   output logic [LAT_W-1:0] lat_q
);
   if (LAT_W < 1) begin : g_bad_w
      $error("pgc_latch: LAT_W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lat_q <= '0;
      else if (wr_en) lat_q <= wr_data;
   end

   // R10: without a write strobe the latch keeps its value
   a_r10_latch_kept: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(lat_q));
   // R6: a write lands on the next edge
   a_r6_latch_take: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> lat_q == $past(wr_data));
endmodule

// File: rtl/pgc_arbiter.sv
module pgc_arbiter
   import pgc_pkg::*;
(
   input  logic     irq_req,
   input  logic     ret_req,
   input  logic     jmp_req,
   input  logic     low_req,
   input  logic     inc_req,
   output pgc_sel_e sel
);
   always_comb begin
      if (irq_req)      sel = PGC_VEC;
      else if (ret_req) sel = PGC_RET;
      else if (jmp_req) sel = PGC_JUMP;
      else if (low_req) sel = PGC_LOW;
      else if (inc_req) sel = PGC_INC;
      else              sel = PGC_HOLD;
   end
endmodule

// File: rtl/pgc_nextval.sv
module pgc_nextval
   import pgc_pkg::*;
#(
   parameter int unsigned PC_W     = 13,
   parameter int unsigned LO_W     = 8,
   parameter int unsigned JMP_W    = 11,
   parameter int unsigned VEC_ADDR = 4,
   localparam int unsigned LAT_W   = PC_W - LO_W
) (
   input  pgc_sel_e         sel,
   input  logic [PC_W-1:0]  pc_q,
   input  logic [LAT_W-1:0] lat_q,
   input  logic [LO_W-1:0]  lo_data,
   input  logic [JMP_W-1:0] jmp_tgt,
   input  logic [PC_W-1:0]  ret_val,
   output logic [PC_W-1:0]  pc_d
);
   localparam int unsigned JHI_W = PC_W - JMP_W;

   logic [PC_W-1:0] jmp_val;
   logic [PC_W-1:0] low_val;
   logic [PC_W-1:0] inc_val;
   logic [PC_W-1:0] vec_val;

   if (JHI_W == 0) begin : g_jmp_full
      assign jmp_val = jmp_tgt;
   end else begin : g_jmp_paged
      assign jmp_val = {lat_q[LAT_W-1 -: JHI_W], jmp_tgt};
   end

   assign low_val = {lat_q, lo_data};
   assign inc_val = pc_q + {{(PC_W-1){1'b0}}, 1'b1};
   assign vec_val = PC_W'(VEC_ADDR);

   always_comb begin
      unique case (sel)
         PGC_VEC:  pc_d = vec_val;
         PGC_RET:  pc_d = ret_val;
         PGC_JUMP: pc_d = jmp_val;
         PGC_LOW:  pc_d = low_val;
         PGC_INC:  pc_d = inc_val;
         default:  pc_d = pc_q;
      endcase
   end
endmodule

// File: rtl/pgc_top.sv
module pgc_top
   import pgc_pkg::*;
#(
   parameter int unsigned PC_W     = 13,
   parameter int unsigned LO_W     = 8,
   parameter int unsigned JMP_W    = 11,
   parameter int unsigned VEC_ADDR = 4,
   localparam int unsigned LAT_W   = PC_W - LO_W,
   localparam int unsigned JHI_W   = PC_W - JMP_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_en,
   input  logic             lo_wr,
   input  logic [LO_W-1:0]  lo_wdata,
   input  logic             jmp_en,
   input  logic [JMP_W-1:0] jmp_tgt,
   input  logic             lat_wr,
   input  logic [LAT_W-1:0] lat_wdata,
   input  logic             ret_ld,
   input  logic [PC_W-1:0]  ret_val,
   input  logic             irq_ld,
   output logic [PC_W-1:0]  pc_q,
   output logic [LO_W-1:0]  lo_rdata
);
   if (LO_W >= PC_W) begin : g_bad_lo
      $error("pgc_top: LO_W must be below PC_W");
   end
   if (JMP_W < LO_W || JMP_W > PC_W) begin : g_bad_jmp
      $error("pgc_top: JMP_W must lie between LO_W and PC_W");
   end
   if (VEC_ADDR >= (1 << PC_W)) begin : g_bad_vec
      $error("pgc_top: VEC_ADDR does not fit in PC_W bits");
   end

   logic [LAT_W-1:0] lat_q;
   logic [PC_W-1:0]  pc_d;
   pgc_sel_e         sel;

   pgc_latch #(.LAT_W(LAT_W)) latch_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (lat_wr),
      .wr_data (lat_wdata),
      .lat_q   (lat_q)
   );

   pgc_arbiter arb_i (
      .irq_req (irq_ld),
      .ret_req (ret_ld),
      .jmp_req (jmp_en),
      .low_req (lo_wr),
      .inc_req (inc_en),
      .sel     (sel)
   );

   pgc_nextval #(
      .PC_W     (PC_W),
      .LO_W     (LO_W),
      .JMP_W    (JMP_W),
      .VEC_ADDR (VEC_ADDR)
   ) next_i (
      .sel     (sel),
      .pc_q    (pc_q),
      .lat_q   (lat_q),
      .lo_data (lo_wdata),
      .jmp_tgt (jmp_tgt),
      .ret_val (ret_val),
      .pc_d    (pc_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc_q <= '0;
      else        pc_q <= pc_d;
   end

   assign lo_rdata = pc_q[LO_W-1:0];

   // R1: counter leaves reset at zero
   a_r1_reset_zero: assert property (@(posedge clk)
      $rose(rst_n) |-> pc_q == '0);
   // R8: interrupt vector wins over everything
   a_r8_vector: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ld |=> pc_q == PC_W'(VEC_ADDR));
   // R7, R9: return load below vector
   a_r7_return: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_ld && !irq_ld) |=> pc_q == $past(ret_val));
   // R5, R9: jump target lands in the low bits
   a_r5_jump_low: assert property (@(posedge clk) disable iff (!rst_n)
      (jmp_en && !ret_ld && !irq_ld) |=> pc_q[JMP_W-1:0] == $past(jmp_tgt));
   if (JHI_W > 0) begin : g_jmp_chk
      // R5: page bits above the target come from the top of the latch
      a_r5_jump_page: assert property (@(posedge clk) disable iff (!rst_n)
         (jmp_en && !ret_ld && !irq_ld) |=>
            pc_q[PC_W-1 -: JHI_W] == $past(lat_q[LAT_W-1 -: JHI_W]));
   end
   // R4, R6: low-byte write uses the latch value held before the edge
   a_r4_low_write: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_wr && !jmp_en && !ret_ld && !irq_ld) |=>
         pc_q == {$past(lat_q), $past(lo_wdata)});
   // R3: increment with wrap
   a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_en && !lo_wr && !jmp_en && !ret_ld && !irq_ld) |=>
         pc_q == PC_W'($past(pc_q) + 1'b1));
   // R3, R6: no request keeps the counter still
   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc_en && !lo_wr && !jmp_en && !ret_ld && !irq_ld) |=> $stable(pc_q));
endmodule

// File: tb/pgc_top_tb_top.sv
`timescale 1ns/1ps
module pgc_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        inc_en = 1'b0, lo_wr = 1'b0, jmp_en = 1'b0;
   logic        lat_wr = 1'b0, ret_ld = 1'b0, irq_ld = 1'b0;
   logic [7:0]  lo_wdata = '0;
   logic [10:0] jmp_tgt = '0;
   logic [4:0]  lat_wdata = '0;
   logic [12:0] ret_val = '0;
   logic [12:0] pc_q;
   logic [7:0]  lo_rdata;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;
   int mpc = 0;
   int mlat = 0;

   always #5 clk = ~clk;

   pgc_top dut_i (
      .clk(clk), .rst_n(rst_n), .inc_en(inc_en), .lo_wr(lo_wr),
      .lo_wdata(lo_wdata), .jmp_en(jmp_en), .jmp_tgt(jmp_tgt),
      .lat_wr(lat_wr), .lat_wdata(lat_wdata), .ret_ld(ret_ld),
      .ret_val(ret_val), .irq_ld(irq_ld), .pc_q(pc_q), .lo_rdata(lo_rdata)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // one cycle: drive at negedge, model, sample at next negedge
   task automatic step(input bit i_irq, input bit i_ret, input bit i_jmp,
                       input bit i_lo, input bit i_inc, input bit i_lw,
                       input int rv, input int jt, input int ld, input int lwd,
                       input string tag);
      int e;
      irq_ld = i_irq; ret_ld = i_ret; jmp_en = i_jmp; lo_wr = i_lo;
      inc_en = i_inc; lat_wr = i_lw;
      ret_val = 13'(rv); jmp_tgt = 11'(jt); lo_wdata = 8'(ld); lat_wdata = 5'(lwd);
      if (i_irq)      e = 4;
      else if (i_ret) e = rv % 8192;
      else if (i_jmp) e = (mlat / 8) * 2048 + (jt % 2048);
      else if (i_lo)  e = mlat * 256 + (ld % 256);
      else if (i_inc) e = (mpc + 1) % 8192;
      else            e = mpc;
      if (i_lw) mlat = lwd % 32;
      mpc = e;
      @(posedge clk);
      @(negedge clk);
      chk(tag, int'(pc_q), e);
      chk("R2 low byte mirror", int'(lo_rdata), e % 256);
   endtask

   task automatic lo_w(input int d, input string tag);
      step(0, 0, 0, 1, 0, 0, 0, 0, d, 0, tag);
   endtask
   task automatic lat_w(input int l, input string tag);
      step(0, 0, 0, 0, 0, 1, 0, 0, 0, l, tag);
   endtask
   task automatic inc1(input string tag);
      step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog act=running exp=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset pc", int'(pc_q), 0);
      chk("R2 reset low byte", int'(lo_rdata), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 pc after release", int'(pc_q), 0);
      lo_w(8'h55, "R1 latch zero after reset");

      // R4 / R6: every latch value, edge data
      for (int l = 0; l < 32; l++) begin
         lat_w(l, "R6 latch write leaves pc");
         lo_w(8'h00, "R4 low write");
         lo_w(8'h7F, "R4 low write");
         lo_w(8'h80, "R4 low write");
         lo_w(8'hFF, "R4 low write");
         lo_w((l * 29) % 256, "R4 low write");
         inc1("R3 increment");
      end

      // R4: computed jump crossing 0xFF wraps within page
      lat_w(3, "R6 latch write leaves pc");
      lo_w(8'hF0, "R4 table base");
      lo_w((8'hF0 + 8'h20) % 256, "R4 computed jump wraps in page");
      chk("R4 page kept", int'(pc_q), 13'h0310);

      // R5: jump under every latch value
      for (int l = 0; l < 32; l++) begin
         lat_w(l, "R6 latch write leaves pc");
         step(0, 0, 1, 0, 0, 0, 0, 11'h000, 0, 0, "R5 jump");
         step(0, 0, 1, 0, 0, 0, 0, 11'h3FF, 0, 0, "R5 jump");
         step(0, 0, 1, 0, 0, 0, 0, 11'h400, 0, 0, "R5 jump");
         step(0, 0, 1, 0, 0, 0, 0, 11'h7FF, 0, 0, "R5 jump");
         step(0, 0, 1, 0, 0, 0, 0, (l * 37) % 2048, 0, 0, "R5 jump");
         lo_w(8'hA5, "R10 latch kept after jump");
      end

      // R3: carry into page and 13-bit wrap, then hold
      lat_w(0, "R6 latch write leaves pc");
      lo_w(8'hFE, "R4 low write");
      for (int i = 0; i < 3; i++) inc1("R3 increment across page");
      chk("R3 page carry", int'(pc_q), 13'h0101);
      lat_w(31, "R6 latch write leaves pc");
      lo_w(8'hFD, "R4 low write");
      for (int i = 0; i < 4; i++) inc1("R3 increment wrap");
      chk("R3 wrap to zero", int'(pc_q), 13'h0001);
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R3 hold");
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R3 hold");

      // R7 / R8 / R10
      lat_w(5'h15, "R6 latch write leaves pc");
      step(0, 1, 0, 0, 0, 0, 13'h0000, 0, 0, 0, "R7 return load");
      step(0, 1, 0, 0, 0, 0, 13'h1FFF, 0, 0, 0, "R7 return load");
      step(0, 1, 0, 0, 0, 0, 13'h1234, 0, 0, 0, "R7 return load");
      lo_w(8'h3C, "R10 latch kept after return");
      step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8 vector load");
      chk("R8 vector value", int'(pc_q), 13'h0004);
      lo_w(8'hC3, "R10 latch kept after vector");

      // R6: same-cycle latch write uses the old latch
      lat_w(5'h02, "R6 latch write leaves pc");
      step(0, 0, 0, 1, 0, 1, 0, 0, 8'h11, 5'h1C, "R6 old latch used");
      chk("R6 old latch value", int'(pc_q), 13'h0211);
      lo_w(8'h22, "R6 new latch after edge");

      // R9: every strobe combination
      for (int m = 0; m < 64; m++) begin
         step(m[4], m[3], m[2], m[1], m[0], m[5],
              (m * 131 + 7) % 8192, (m * 53 + 1) % 2048, (m * 19) % 256,
              (m * 7 + 3) % 32, "R9 priority");
         lo_w(m * 3, "R10 latch after mixed loads");
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule